// File: doc/BRIEF.md
# Synchronous Command Inserter for a Coded Ethernet Transmit Stream

This block sits in the transmit direction between a gigabit Ethernet MAC's coded-symbol output (one 8-bit symbol per clock, each with a K-character flag and a running-disparity bit) and the serializer. It adds short synchronous commands to the line without touching any frame. A command is two symbols: a tag K-character and one command byte, so 256 distinct commands are possible. The three fields of each symbol travel through the pipeline together.

The normal route through the block is a short pipeline. A command waits until the next symbol due out is the first symbol of an idle pair. The block then sends the tag and the byte in that symbol's place and moves all later traffic onto a path that is two symbols deeper, so nothing is lost. The slip is removed later inside an inter-frame gap. When the pair leaving the deep path is an idle and the pair behind it is also an idle, the first pair is discarded and the block goes back to the short route. A gap of a single idle pair is never shortened. Commands use a valid/ready handshake. No new command is taken until the block is back on the short route.

Top module: `cmd_inserter`

## Requirements
- R1: While reset is held, and on the first edge after it, tx_data, tx_is_k, tx_disp and cmd_ready are all 0.
- R2: On the short route, a symbol sampled on one rising edge appears on the outputs after the next rising edge, with its data, K flag and disparity bit unchanged.
- R3: Symbols sampled on the first edge after reset release have even phase, and the phase alternates from then on. An idle lead is a symbol with K flag 1, data 0xBC and even phase. cmd_ready is 1 exactly when the block is on the short route and the symbol next due out is an idle lead.
- R4: On a handshake edge the output becomes the tag (data 0x3C, K flag 1). On the next edge the output is the accepted command byte with K flag 0. Both carry the disparity bit of the idle lead they displace.
- R5: After an insertion every input symbol still leaves in order, three edges after it is sampled, with its side bits unchanged.
- R6: From a handshake until the block is back on the short route, cmd_ready stays 0.
- R7: On the deep route, when the symbol next due out is an idle lead and the symbol two positions behind it is also an idle lead, the first idle pair is dropped. The output continues from the second idle lead, and latency returns to that of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_data | input | 8 | Incoming symbol value from the MAC |
| sym_is_k | input | 1 | Incoming symbol is a K-character |
| sym_disp | input | 1 | Running-disparity bit of the incoming symbol |
| cmd_valid | input | 1 | A command is offered |
| cmd_byte | input | 8 | Command code |
| cmd_ready | output | 1 | Command taken on this edge if cmd_valid is high |
| tx_data | output | 8 | Outgoing symbol value to the serializer |
| tx_is_k | output | 1 | Outgoing symbol is a K-character |
| tx_disp | output | 1 | Running-disparity bit of the outgoing symbol |

## Verification
A symbol sampled on edge e leaves after edge e+1 on the short route and after edge e+3 on the deep route. The tag appears on the handshake edge and the byte on the edge after it. cmd_ready is combinational and is valid before the edge that uses it. The bench drives inputs and checks cmd_ready at each falling edge, then compares all three outputs 1 ns after the next rising edge with a behavioural model that indexes a per-edge record of input symbols. Each comparison is labelled with the requirement that governs that edge (short, tag/byte, deep or drop).

// File: rtl/cmdins_pkg.sv
package cmdins_pkg;
  localparam int SYM_W    = 8;
  localparam int PAIR_LEN = 2;               // one idle = two symbols
  localparam int TAP_N    = PAIR_LEN + 1;    // head .. tail of the pipeline

  typedef struct packed {
    logic [SYM_W-1:0] data;
    logic             is_k;
    logic             disp;
    logic             odd;                   // word phase of the symbol
  } sym_t;

  typedef enum logic [1:0] {PICK_HEAD, PICK_TAIL, PICK_TAG, PICK_CMD} pick_t;
  typedef enum logic [1:0] {ST_SHORT, ST_BYTE, ST_LONG} mode_t;

  // first symbol of an idle pair, on the even word phase
  function automatic logic is_gap_lead(sym_t s, logic [SYM_W-1:0] idle_code);
    return s.is_k && !s.odd && (s.data == idle_code);
  endfunction
endpackage

// File: rtl/cmdins_delay.sv
module cmdins_delay
  import cmdins_pkg::*;
#(
  parameter int DEPTH = TAP_N
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_t din,
  output sym_t taps [DEPTH]
);
  sym_t stage [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
    assign taps[g] = stage[g];
  end
endmodule

// File: rtl/cmdins_ctrl.sv
module cmdins_ctrl
  import cmdins_pkg::*;
#(
  parameter logic [SYM_W-1:0] IDLE_CODE = 8'hBC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sym_t             head,
  input  sym_t             tail,
  input  logic             cmd_valid,
  input  logic [SYM_W-1:0] cmd_byte,
  output logic             cmd_ready,
  output pick_t            pick,
  output logic [SYM_W-1:0] cmd_q,
  output logic             disp_q,
  output logic             take,
  output logic             drop
);
  mode_t mode_q, mode_d;
  logic  head_gap, tail_gap;

  assign head_gap  = is_gap_lead(head, IDLE_CODE);
  assign tail_gap  = is_gap_lead(tail, IDLE_CODE);
  assign cmd_ready = (mode_q == ST_SHORT) && head_gap;
  assign take      = cmd_valid && cmd_ready;
  assign drop      = (mode_q == ST_LONG) && tail_gap && head_gap;

  always_comb begin
    mode_d = mode_q;
    pick   = PICK_HEAD;
    unique case (mode_q)
      ST_SHORT: if (take) begin pick = PICK_TAG; mode_d = ST_BYTE; end
      ST_BYTE:  begin pick = PICK_CMD; mode_d = ST_LONG; end
      ST_LONG:  if (drop) mode_d = ST_SHORT; else pick = PICK_TAIL;
      default:  mode_d = ST_SHORT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ST_SHORT;
      cmd_q  <= '0;
      disp_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (take) begin
        cmd_q  <= cmd_byte;
        disp_q <= head.disp;
      end
    end
  end

  // R6: no second command is taken straight after a handshake
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !cmd_ready);
  // R5: the byte is always followed by the deep route or an immediate drop
  a_r5_byte_then_long: assert property (@(posedge clk) disable iff (!rst_n)
    (pick == PICK_CMD) |=> (pick == PICK_TAIL || pick == PICK_HEAD));
  // R7: a drop leaves the block on the short route
  a_r7_drop_returns: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (pick != PICK_TAIL && pick != PICK_CMD));
endmodule

// File: rtl/cmd_inserter.sv
module cmd_inserter
  import cmdins_pkg::*;
#(
  parameter logic [SYM_W-1:0] TAG_CODE  = 8'h3C,
  parameter logic [SYM_W-1:0] IDLE_CODE = 8'hBC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             sym_is_k,
  input  logic             sym_disp,
  input  logic             cmd_valid,
  input  logic [SYM_W-1:0] cmd_byte,
  output logic             cmd_ready,
  output logic [SYM_W-1:0] tx_data,
  output logic             tx_is_k,
  output logic             tx_disp
);
  logic             odd_q;
  sym_t             din;
  sym_t             taps [TAP_N];
  sym_t             out_q;
  pick_t            pick;
  logic [SYM_W-1:0] cmd_q;
  logic             disp_q, take, drop;

  always_ff @(posedge clk) begin
    if (!rst_n) odd_q <= 1'b0;
    else        odd_q <= ~odd_q;
  end

  assign din = '{data: sym_data, is_k: sym_is_k, disp: sym_disp, odd: odd_q};

  cmdins_delay #(.DEPTH(TAP_N)) u_delay (
    .clk(clk), .rst_n(rst_n), .din(din), .taps(taps)
  );

  cmdins_ctrl #(.IDLE_CODE(IDLE_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .head(taps[0]), .tail(taps[TAP_N-1]),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
    .pick(pick), .cmd_q(cmd_q), .disp_q(disp_q), .take(take), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else begin
      unique case (pick)
        PICK_HEAD: out_q <= taps[0];
        PICK_TAIL: out_q <= taps[TAP_N-1];
        PICK_TAG:  out_q <= '{data: TAG_CODE, is_k: 1'b1, disp: taps[0].disp, odd: 1'b0};
        PICK_CMD:  out_q <= '{data: cmd_q, is_k: 1'b0, disp: disp_q, odd: 1'b1};
        default:   out_q <= taps[0];
      endcase
    end
  end

  assign tx_data = out_q.data;
  assign tx_is_k = out_q.is_k;
  assign tx_disp = out_q.disp;

  // R4: tag one edge after the handshake, byte on the next
  a_r4_tag_out: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) |-> (tx_is_k && tx_data == TAG_CODE));
  a_r4_byte_out: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take, 2) |-> (!tx_is_k && tx_data == $past(cmd_byte, 2)));
  // R7: after a drop the output is an idle lead
  a_r7_drop_yields_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drop) |-> (tx_is_k && tx_data == IDLE_CODE));
  // R2: on the short route the head symbol leaves unchanged
  a_r2_short_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pick == PICK_HEAD) |-> (tx_data == $past(taps[0].data) && tx_disp == $past(taps[0].disp)));
endmodule

// File: tb/cmd_inserter_test.sv
module cmd_inserter_test;
  localparam int NCYC = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sym_data = '0;
  logic       sym_is_k = 1'b0, sym_disp = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       cmd_ready;
  logic [7:0] tx_data;
  logic       tx_is_k, tx_disp;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] xd [NCYC];
  logic       xk [NCYC];
  logic       xp [NCYC];
  logic [9:0] sq [$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  cmd_inserter uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] step(logic [15:0] v);
    return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
  endfunction

  function automatic logic midle(int j);
    return (j >= 0) && xk[j] && (xd[j] == 8'hBC) && (j % 2 == 0);
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refill(int i);
    int nf = 3 + (i * 5) % 6;
    int ng = (i % 4) + 1;
    for (int p = 0; p < nf; p++) begin
      for (int s = 0; s < 2; s++) begin
        lfsr = step(lfsr);
        if (p == 0 && s == 0) sq.push_back({8'hFB, 1'b1, lfsr[3]});
        else                  sq.push_back({lfsr[15:8], 1'b0, lfsr[3]});
      end
    end
    for (int p = 0; p < ng; p++) begin
      lfsr = step(lfsr); sq.push_back({8'hBC, 1'b1, lfsr[3]});
      lfsr = step(lfsr); sq.push_back({8'h50, 1'b0, lfsr[3]});
    end
  endtask

  initial begin
    int mst = 0, seg = 0, inserts = 0, drops = 0;
    logic pend = 1'b0, exp_rdy, took;
    logic [7:0] pbyte = '0, cbyte = '0;
    logic cdisp = 1'b0;
    logic [9:0] e_out, sv;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {tx_data, tx_is_k, tx_disp}, 10'h0);
    check("R1", {9'h0, cmd_ready}, 10'h0);
    rst_n = 1'b1;

    for (int e = 0; e < NCYC; e++) begin
      if (sq.size() == 0) begin refill(seg); seg++; end
      sv = sq.pop_front();
      sym_data = sv[9:2]; sym_is_k = sv[1]; sym_disp = sv[0];
      if (!pend && (e % 23 == 3)) begin pend = 1'b1; pbyte = e[7:0] ^ 8'h5A; end
      cmd_valid = pend; cmd_byte = pbyte;

      exp_rdy = (mst == 0) && midle(e - 1);
      check(mst == 0 ? "R3" : "R6", {9'h0, cmd_ready}, {9'h0, exp_rdy});

      took = 1'b0;
      case (mst)
        0: if (pend && exp_rdy) begin
             e_out = {8'h3C, 1'b1, xp[e-1]}; cdisp = xp[e-1]; cbyte = pbyte;
             mst = 1; took = 1'b1; inserts++; tag = "R4";
           end else begin
             e_out = (e >= 1) ? {xd[e-1], xk[e-1], xp[e-1]} : 10'h0; tag = "R2";
           end
        1: begin e_out = {cbyte, 1'b0, cdisp}; mst = 2; tag = "R4"; end
        default:
           if (midle(e - 3) && midle(e - 1)) begin
             e_out = {xd[e-1], xk[e-1], xp[e-1]}; mst = 0; drops++; tag = "R7";
           end else begin
             e_out = (e >= 3) ? {xd[e-3], xk[e-3], xp[e-3]} : 10'h0; tag = "R5";
           end
      endcase
      xd[e] = sym_data; xk[e] = sym_is_k; xp[e] = sym_disp;

      @(posedge clk);
      if (took) pend = 1'b0;
      #1;
      if (e == 0) check("R1", {tx_data, tx_is_k, tx_disp}, 10'h0);
      check(tag, {tx_data, tx_is_k, tx_disp}, e_out);
      @(negedge clk);
    end

    total++; if (inserts == 0) begin bad++; $display("FAIL R4: actual=%0d expected=>0 inserts", inserts); end
    total++; if (drops == 0) begin bad++; $display("FAIL R7: actual=%0d expected=>0 drops", drops); end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule